// File: doc/BRIEF.md
# Dimming and Flash Timing Generator

This block produces the timing of a multiplexed dot-matrix character display from a single display clock. One divider chain runs through it. A slot counter splits each refresh frame into seven row slots of 32 clocks and gives the row index and a start-of-slot strobe. A duty gate inside each slot sets the LED drive window from a 3-bit brightness code. A frame counter gives the slow on/off phase that drives per-character flashing and whole-display blinking.

For each of the eight characters the block gives a visible flag. The flag combines the on/off phase with a per-character flash attribute vector and two enables taken from the control word. Downstream logic ANDs the row drive with these flags and with the glyph dots. All counters restart on reset, so several units that share a clock and a reset flash and blink in step.

Top module: `dimflash_timing`

## Requirements
- R1: While reset is held, and on the first sampled cycle after it is released, `row_idx` is 0, `row_strobe` is 1 and `char_visible` is all ones, provided the enables are clear.
- R2: With t counting clocks since reset was released, `row_strobe` is 1 exactly when t mod 32 is 0, and `row_idx` equals (t div 32) mod 7. One frame is 7 slots, or 224 clocks.
- R3: Each slot is divided into 16 steps of 2 clocks, with step = (t mod 32) div 2. `drive_en` is 1 when step < N, where N for `bright_code` 0 to 7 is 15, 12, 8, 6, 4, 3, 2, 0.
- R4: Code 7 keeps `drive_en` at 0 for the whole slot. Code 0 still turns drive off for the last step of each slot (clocks 30 and 31).
- R5: The on/off phase is "on" while (t div 224) mod 128 is below 64 and "off" otherwise. The period is 28,672 clocks, and the first half after reset is "on".
- R6: With `flash_en`=1 and `blink_en`=0, `char_visible[i]` is the inverse of `flash_attr[i]` during the off half, and 1 during the on half. Bit i of the attribute vector maps to bit i of the visible vector.
- R7: With `flash_en`=0 and `blink_en`=0, `flash_attr` has no effect and every flag is 1 in both halves.
- R8: With `blink_en`=1, all flags are 0 during the off half and all are 1 during the on half, whatever the values of `flash_en` and `flash_attr`.
- R9: A reset applied in mid-run restarts the row, slot and phase counting from t = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bright_code | input | 3 | Brightness code, 0 brightest, 7 blank |
| flash_en | input | 1 | Enable the per-character flash attribute |
| blink_en | input | 1 | Blink all characters; overrides flash |
| flash_attr | input | 8 | Flash attribute, one bit per character |
| row_idx | output | 3 | Row currently being scanned, 0 to 6 |
| row_strobe | output | 1 | High on the first clock of each row slot |
| drive_en | output | 1 | Row drive window from the brightness code |
| char_visible | output | 8 | Per-character visible flag |

## Verification
The scan pattern is followed cycle by cycle through more than two frames, so that a wrong slot length or a wrong row wrap point can be told apart. Every brightness code is applied over a full slot, which separates off-by-one gate limits and shows the forced off step at full brightness. The attribute pattern 0x5A is checked at the last "on" clock and the first "off" clock under flash only, under no enables, under blink only and under blink with flash. This tells apart which bits follow the attribute, where the half-period boundary falls, and that blink takes priority. A reset in mid-run followed by a run to the next boundary shows that the counters restart.

// File: rtl/dimflash_pkg.sv
package dimflash_pkg;

   typedef logic [2:0] bright_t;

   // Number of lit steps out of 16 for each brightness code, scaled to 2**step_w steps.
   function automatic int unsigned duty_steps(bright_t code, int unsigned step_w);
      int unsigned base;
      case (code)
         3'd0:    base = 15;
         3'd1:    base = 12;
         3'd2:    base = 8;
         3'd3:    base = 6;
         3'd4:    base = 4;
         3'd5:    base = 3;
         3'd6:    base = 2;
         default: base = 0;
      endcase
      return (base * (32'd1 << step_w)) / 16;
   endfunction

endpackage

// File: rtl/dft_slot_counter.sv
module dft_slot_counter #(
   parameter int unsigned SLOT_W = 5,
   parameter int unsigned N_ROWS = 7,
   parameter int unsigned ROW_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [SLOT_W-1:0] slot_pos,
   output logic [ROW_W-1:0]  row,
   output logic              strobe,
   output logic              frame_end
);
   localparam logic [SLOT_W-1:0] SLOT_LAST = {SLOT_W{1'b1}};
   localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(N_ROWS - 1);

   logic slot_end;

   assign slot_end  = (slot_pos == SLOT_LAST);
   assign frame_end = slot_end && (row == ROW_LAST);
   assign strobe    = (slot_pos == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_pos <= '0;
         row      <= '0;
      end else begin
         slot_pos <= slot_pos + 1'b1;
         if (slot_end) begin
            row <= (row == ROW_LAST) ? '0 : row + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dft_phase_counter.sv
module dft_phase_counter #(
   parameter int unsigned PHASE_W     = 7,
   parameter bit          BLANK_FIRST = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_end,
   output logic off_half
);
   logic [PHASE_W-1:0] frame_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_cnt <= '0;
      end else if (frame_end) begin
         frame_cnt <= frame_cnt + 1'b1;
      end
   end

   generate
      if (BLANK_FIRST) begin : g_off_first
         assign off_half = ~frame_cnt[PHASE_W-1];
      end else begin : g_on_first
         assign off_half = frame_cnt[PHASE_W-1];
      end
   endgenerate
endmodule

// File: rtl/dft_duty_gate.sv
module dft_duty_gate
   import dimflash_pkg::*;
#(
   parameter int unsigned SLOT_W = 5,
   parameter int unsigned STEP_W = 4
) (
   input  logic [SLOT_W-1:0] slot_pos,
   input  bright_t           code,
   output logic              drive_en
);
   logic [STEP_W-1:0] step;
   logic [STEP_W:0]   n_on;

   assign step     = slot_pos[SLOT_W-1 -: STEP_W];
   assign n_on     = (STEP_W+1)'(duty_steps(code, STEP_W));
   assign drive_en = ({1'b0, step} < n_on);
endmodule

// File: rtl/dft_visibility.sv
module dft_visibility #(
   parameter int unsigned N_CHARS = 8
) (
   input  logic               off_half,
   input  logic               flash_en,
   input  logic               blink_en,
   input  logic [N_CHARS-1:0] attr,
   output logic [N_CHARS-1:0] visible
);
   generate
      for (genvar i = 0; i < N_CHARS; i++) begin : g_char
         always_comb begin
            if (!off_half)     visible[i] = 1'b1;
            else if (blink_en) visible[i] = 1'b0;
            else if (flash_en) visible[i] = ~attr[i];
            else               visible[i] = 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/dimflash_timing.sv
module dimflash_timing
   import dimflash_pkg::*;
#(
   parameter int unsigned N_ROWS      = 7,
   parameter int unsigned SLOT_W      = 5,
   parameter int unsigned STEP_W      = 4,
   parameter int unsigned PHASE_W     = 7,
   parameter int unsigned N_CHARS     = 8,
   parameter bit          BLANK_FIRST = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         bright_code,
   input  logic               flash_en,
   input  logic               blink_en,
   input  logic [N_CHARS-1:0] flash_attr,
   output logic [2:0]         row_idx,
   output logic               row_strobe,
   output logic               drive_en,
   output logic [N_CHARS-1:0] char_visible
);
   localparam int unsigned ROW_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1;

   generate
      if (ROW_W > 3)        begin : g_bad_rows  $error("N_ROWS does not fit row_idx"); end
      if (STEP_W > SLOT_W)  begin : g_bad_step  $error("STEP_W must not exceed SLOT_W"); end
      if (PHASE_W < 1)      begin : g_bad_phase $error("PHASE_W must be at least 1"); end
   endgenerate

   logic [SLOT_W-1:0] slot_pos;
   logic [ROW_W-1:0]  row;
   logic              frame_end;
   logic              off_half;

   dft_slot_counter #(.SLOT_W(SLOT_W), .N_ROWS(N_ROWS), .ROW_W(ROW_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .slot_pos(slot_pos), .row(row),
      .strobe(row_strobe), .frame_end(frame_end)
   );

   dft_phase_counter #(.PHASE_W(PHASE_W), .BLANK_FIRST(BLANK_FIRST)) u_phase (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .off_half(off_half)
   );

   dft_duty_gate #(.SLOT_W(SLOT_W), .STEP_W(STEP_W)) u_gate (
      .slot_pos(slot_pos), .code(bright_t'(bright_code)), .drive_en(drive_en)
   );

   dft_visibility #(.N_CHARS(N_CHARS)) u_vis (
      .off_half(off_half), .flash_en(flash_en), .blink_en(blink_en),
      .attr(flash_attr), .visible(char_visible)
   );

   assign row_idx = 3'(row);
endmodule

// File: rtl/dimflash_timing_chk.sv
module dimflash_timing_chk #(
   parameter int unsigned N_ROWS  = 7,
   parameter int unsigned N_CHARS = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         bright_code,
   input logic               flash_en,
   input logic               blink_en,
   input logic [2:0]         row_idx,
   input logic               row_strobe,
   input logic               drive_en,
   input logic [N_CHARS-1:0] char_visible
);
   localparam logic [2:0] ROW_LAST = 3'(N_ROWS - 1);

   AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      row_idx <= ROW_LAST); // R2

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      row_strobe |=> !row_strobe); // R2

   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !row_strobe |-> $stable(row_idx)); // R2

   AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(row_strobe) |->
         (row_idx == (($past(row_idx) == ROW_LAST) ? 3'd0 : $past(row_idx) + 3'd1))); // R2

   AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (bright_code == 3'd7) |-> !drive_en); // R4

   AST_SLOT_START_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      (row_strobe && bright_code != 3'd7) |-> drive_en); // R3

   AST_NO_FLASH_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_en && !blink_en) |-> (&char_visible)); // R7

   AST_BLINK_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
      blink_en |-> ((char_visible == '0) || (&char_visible))); // R8
endmodule

bind dimflash_timing dimflash_timing_chk #(.N_ROWS(N_ROWS), .N_CHARS(N_CHARS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bright_code(bright_code), .flash_en(flash_en),
   .blink_en(blink_en), .row_idx(row_idx), .row_strobe(row_strobe),
   .drive_en(drive_en), .char_visible(char_visible)
);

// File: tb/test_dimflash_timing.sv
module test_dimflash_timing;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bright_code = 3'd0;
   logic       flash_en = 1'b0;
   logic       blink_en = 1'b0;
   logic [7:0] flash_attr = 8'h00;
   logic [2:0] row_idx;
   logic       row_strobe;
   logic       drive_en;
   logic [7:0] char_visible;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int wdog = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
      wdog <= wdog + 1;
   end

   dimflash_timing i_dimflash_timing (
      .clk(clk), .rst_n(rst_n), .bright_code(bright_code), .flash_en(flash_en),
      .blink_en(blink_en), .flash_attr(flash_attr), .row_idx(row_idx),
      .row_strobe(row_strobe), .drive_en(drive_en), .char_visible(char_visible)
   );

   function automatic int n_lit(input logic [2:0] c);
      case (c)
         3'd0: return 15; 3'd1: return 12; 3'd2: return 8; 3'd3: return 6;
         3'd4: return 4;  3'd5: return 3;  3'd6: return 2; default: return 0;
      endcase
   endfunction

   function automatic bit is_off(input int t);
      return ((t / 224) % 128) >= 64;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s at t=%0d: actual=%0h expected=%0h", req, cyc, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic run_to(input int target);
      while (cyc < target) @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic t_reset();
      flash_en = 1'b0; blink_en = 1'b0; bright_code = 3'd0;
      do_reset();
      check("R1 row", row_idx, 0);
      check("R1 strobe", row_strobe, 1);
      check("R1 visible", char_visible, 8'hFF);
   endtask

   task automatic t_scan();
      for (int k = 0; k < 500; k++) begin
         check("R2 row", row_idx, (cyc / 32) % 7);
         check("R2 strobe", row_strobe, (cyc % 32) == 0);
         tick();
      end
   endtask

   task automatic t_gate();
      for (int c = 0; c < 8; c++) begin
         run_to(((cyc + 31) / 32) * 32);
         bright_code = 3'(c);
         #1;
         for (int k = 0; k < 32; k++) begin
            if (c == 0 || c == 7)
               check("R4 gate", drive_en, ((cyc % 32) / 2) < n_lit(3'(c)));
            else
               check("R3 gate", drive_en, ((cyc % 32) / 2) < n_lit(3'(c)));
            tick();
         end
      end
   endtask

   task automatic t_phase();
      flash_attr = 8'h5A;
      flash_en = 1'b1; blink_en = 1'b0;
      run_to(14335);
      check("R5 on half", char_visible, 8'hFF);
      check("R5 phase", is_off(cyc), 0);
      tick();
      check("R6 flash off half", char_visible, 8'hA5);
      check("R5 phase", is_off(cyc), 1);
      flash_en = 1'b0; #1;
      check("R7 attr ignored", char_visible, 8'hFF);
      blink_en = 1'b1; #1;
      check("R8 blink only", char_visible, 8'h00);
      flash_en = 1'b1; #1;
      check("R8 blink over flash", char_visible, 8'h00);
      run_to(28671);
      check("R8 still off", char_visible, 8'h00);
      tick();
      check("R5 period end", char_visible, 8'hFF);
      blink_en = 1'b0; #1;
      check("R6 flash on half", char_visible, 8'hFF);
   endtask

   task automatic t_resync();
      run_to(28700);
      do_reset();
      check("R9 row", row_idx, 0);
      check("R9 strobe", row_strobe, 1);
      run_to(100);
      check("R9 row later", row_idx, 3);
      flash_en = 1'b1; blink_en = 1'b0; flash_attr = 8'h0F;
      run_to(14336);
      check("R9 phase restart", char_visible, 8'hF0);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_scan();
            t_gate();
            t_phase();
            t_resync();
         end
         begin
            wait (wdog > 100000);
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=100000", wdog);
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule